// File: doc/BRIEF.md
# Staged Pipeline Control Generator

This block turns the instruction sitting in the decode stage of a five-stage in-order pipeline into control strobes. It then carries them forward with the instruction. The strobes fall into three groups, each named after the stage that consumes it:

- **Execute group:** destination-register select, ALU operation class and second-operand select.
- **Memory group:** branch, memory read and memory write.
- **Writeback group:** register write and load-result select.

The decode-to-execute register holds all three groups. The execute-to-memory register keeps only the memory and writeback groups. The memory-to-writeback register keeps only the writeback group. The stored control word therefore shrinks as each group is used.

The surrounding datapath uses two requests to shape the flow:

- **Bubble request:** a hazard unit asks for a bubble when the decoded instruction must wait. A harmless all-zero control word then enters the execute stage in place of the instruction.
- **Flush request:** this squashes the instruction being decoded and the instruction in execute. The instruction already past execute still completes.

The block does not implement the datapath, ALU function decode, register file or memories.

Top module: `stageCtlPipe`

## Requirements
- R1: A non-zero word whose opcode field (bits 31:26) is 0 (register format) yields execute group regDst=1, aluOp=2'b10, aluSrc=0; memory group branch/read/write=0/0/0; writeback group regWrite=1, memToReg=0.
- R2: Opcode 6'h23 (load) yields regDst=0, aluOp=2'b00, aluSrc=1; branch/read/write=0/1/0; regWrite=1, memToReg=1.
- R3: Opcode 6'h2B (store) yields regDst=0, aluOp=2'b00, aluSrc=1; branch/read/write=0/0/1; regWrite=0, memToReg=0.
- R4: Opcode 6'h04 (branch on equal) yields regDst=0, aluOp=2'b01, aluSrc=0; branch/read/write=1/0/0; regWrite=0, memToReg=0.
- R5: The all-zero instruction word, and every opcode not listed in R1 to R4, yields all-zero control in every group.
- R6: For an instruction presented before clock edge k:
  - the execute group appears on the execute outputs after edge k;
  - the memory group appears on the memory outputs after edge k+1;
  - the writeback group appears on the writeback outputs after edge k+2.
- R7: When bubbleReq is high at an edge, the decode-to-execute register loads all-zero control. That zero word then moves down the pipe, so the instruction presented at that edge never causes a memory or register write. Older instructions still complete.
- R8: When flushReq is high at an edge, both the decode-to-execute and execute-to-memory registers load all-zero control. The memory-to-writeback register still takes its normal value.
- R9: An active-low rst_n clears all three control sections at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instrWord | input | 32 | Instruction word in the decode stage |
| bubbleReq | input | 1 | Insert a zero-control bubble into execute |
| flushReq | input | 1 | Squash the decode and execute instructions |
| exRegDst | output | 1 | Execute stage: destination-register select |
| exAluOp | output | 2 | Execute stage: ALU operation class |
| exAluSrc | output | 1 | Execute stage: second-operand select |
| memBranch | output | 1 | Memory stage: branch |
| memRead | output | 1 | Memory stage: memory read |
| memWrite | output | 1 | Memory stage: memory write |
| wbRegWrite | output | 1 | Writeback stage: register write |
| wbMemToReg | output | 1 | Writeback stage: select load data for writeback |

## Verification
An instruction driven before edge k shows its execute group one register later (after edge k), its memory group two registers later (after edge k+1) and its writeback group three registers later (after edge k+2). The vector walk drives a new instruction every cycle. After each edge it compares each output group against the vector that entered one, two or three edges earlier, so three instructions are checked in flight at once. Bubble and flush tests sample on the cycle the squashed slot reaches each stage, and also on the cycle an older instruction should still reach writeback.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  typedef struct packed {
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrc;
  } exCtl_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memCtl_t;

  typedef struct packed {
    logic regWrite;
    logic memToReg;
  } wbCtl_t;

  typedef struct packed {
    exCtl_t  ex;
    memCtl_t mem;
    wbCtl_t  wb;
  } idExCtl_t;

  typedef struct packed {
    memCtl_t mem;
    wbCtl_t  wb;
  } exMemCtl_t;

  typedef struct packed {
    logic zeroIdEx;
    logic zeroExMem;
  } stageStrobe_t;

endpackage

// File: rtl/opDecoder.sv
module opDecoder
  import ctl_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OP_LSB  = 26
) (
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               bubbleReq,
  input  logic               flushReq,
  output idExCtl_t           ctlWord,
  output stageStrobe_t       strobes
);

  logic [OP_W-1:0] opcode;
  logic            wordIsZero;

  assign opcode     = instrWord[OP_LSB +: OP_W];
  assign wordIsZero = (instrWord == '0);

  always_comb begin
    ctlWord = '0;
    if (!wordIsZero) begin
      case (opcode)
        OP_REG: begin
          ctlWord.ex.regDst   = 1'b1;
          ctlWord.ex.aluOp    = 2'b10;
          ctlWord.wb.regWrite = 1'b1;
        end
        OP_LOAD: begin
          ctlWord.ex.aluSrc   = 1'b1;
          ctlWord.mem.memRead = 1'b1;
          ctlWord.wb.regWrite = 1'b1;
          ctlWord.wb.memToReg = 1'b1;
        end
        OP_STORE: begin
          ctlWord.ex.aluSrc    = 1'b1;
          ctlWord.mem.memWrite = 1'b1;
        end
        OP_BEQ: begin
          ctlWord.ex.aluOp   = 2'b01;
          ctlWord.mem.branch = 1'b1;
        end
        default: ctlWord = '0;
      endcase
    end
  end

  assign strobes.zeroIdEx  = bubbleReq | flushReq;
  assign strobes.zeroExMem = flushReq;

endmodule

// File: rtl/ctlStages.sv
module ctlStages
  import ctl_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  idExCtl_t     ctlIn,
  input  stageStrobe_t strobes,
  output idExCtl_t     idExQ,
  output exMemCtl_t    exMemQ,
  output wbCtl_t       memWbQ
);

  exMemCtl_t exMemNext;

  assign exMemNext.mem = idExQ.mem;
  assign exMemNext.wb  = idExQ.wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idExQ  <= '0;
      exMemQ <= '0;
      memWbQ <= '0;
    end else begin
      idExQ  <= strobes.zeroIdEx  ? '0 : ctlIn;
      exMemQ <= strobes.zeroExMem ? '0 : exMemNext;
      memWbQ <= exMemQ.wb;
    end
  end

endmodule

// File: rtl/stageCtlPipe.sv
module stageCtlPipe
  import ctl_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OP_LSB  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               bubbleReq,
  input  logic               flushReq,
  output logic               exRegDst,
  output logic [1:0]         exAluOp,
  output logic               exAluSrc,
  output logic               memBranch,
  output logic               memRead,
  output logic               memWrite,
  output logic               wbRegWrite,
  output logic               wbMemToReg
);

  idExCtl_t     ctlWord;
  stageStrobe_t strobes;
  idExCtl_t     idExQ;
  exMemCtl_t    exMemQ;
  wbCtl_t       memWbQ;

  opDecoder #(.INSTR_W(INSTR_W), .OP_LSB(OP_LSB)) u_dec (
    .instrWord(instrWord),
    .bubbleReq(bubbleReq),
    .flushReq (flushReq),
    .ctlWord  (ctlWord),
    .strobes  (strobes)
  );

  ctlStages u_stages (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctlIn  (ctlWord),
    .strobes(strobes),
    .idExQ  (idExQ),
    .exMemQ (exMemQ),
    .memWbQ (memWbQ)
  );

  assign exRegDst   = idExQ.ex.regDst;
  assign exAluOp    = idExQ.ex.aluOp;
  assign exAluSrc   = idExQ.ex.aluSrc;
  assign memBranch  = exMemQ.mem.branch;
  assign memRead    = exMemQ.mem.memRead;
  assign memWrite   = exMemQ.mem.memWrite;
  assign wbRegWrite = memWbQ.regWrite;
  assign wbMemToReg = memWbQ.memToReg;

endmodule

// File: rtl/ctlPipeChecker.sv
module ctlPipeChecker
  import ctl_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      bubbleReq,
  input logic      flushReq,
  input idExCtl_t  idExQ,
  input exMemCtl_t exMemQ,
  input wbCtl_t    memWbQ
);

  // R6: memory group advances from execute unless squashed
  assert_mem_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flushReq) |-> (exMemQ.mem == $past(idExQ.mem) && exMemQ.wb == $past(idExQ.wb)));

  // R6 and R8: writeback section always takes the memory-stage writeback group
  assert_wb_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (memWbQ == $past(exMemQ.wb)));

  assert_bubble_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bubbleReq |=> (idExQ == '0));

  assert_flush_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |=> (idExQ == '0 && exMemQ == '0));

  // R2: a memory read in flight always carries the load writeback pattern
  assert_load_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exMemQ.mem.memRead |-> (exMemQ.wb.regWrite && exMemQ.wb.memToReg));

  // R3: a store in flight never requests a register write
  assert_store_no_regwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exMemQ.mem.memWrite |-> !exMemQ.wb.regWrite);

endmodule

bind stageCtlPipe ctlPipeChecker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bubbleReq(bubbleReq),
  .flushReq (flushReq),
  .idExQ    (idExQ),
  .exMemQ   (exMemQ),
  .memWbQ   (memWbQ)
);

// File: tb/sim_stageCtlPipe.sv
`timescale 1ns/1ps
module sim_stageCtlPipe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instrWord = '0;
  logic        bubbleReq = 1'b0;
  logic        flushReq = 1'b0;
  logic        exRegDst, exAluSrc, memBranch, memRead, memWrite, wbRegWrite, wbMemToReg;
  logic [1:0]  exAluOp;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  stageCtlPipe u0 (
    .clk(clk), .rst_n(rst_n), .instrWord(instrWord),
    .bubbleReq(bubbleReq), .flushReq(flushReq),
    .exRegDst(exRegDst), .exAluOp(exAluOp), .exAluSrc(exAluSrc),
    .memBranch(memBranch), .memRead(memRead), .memWrite(memWrite),
    .wbRegWrite(wbRegWrite), .wbMemToReg(wbMemToReg)
  );

  // {word, ex{regDst,aluOp,aluSrc}, mem{branch,read,write}, wb{regWrite,memToReg}}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {32'h00622020, 4'b1100, 3'b000, 2'b10},  // R1 register format
    {32'h8C220014, 4'b0001, 3'b010, 2'b11},  // R2 load
    {32'hAC220014, 4'b0001, 3'b001, 2'b00},  // R3 store
    {32'h10220007, 4'b0010, 3'b100, 2'b00},  // R4 branch on equal
    {32'h00000000, 4'b0000, 3'b000, 2'b00},  // R5 all-zero word
    {32'h08000010, 4'b0000, 3'b000, 2'b00},  // R5 unknown opcode 02
    {32'h00000001, 4'b1100, 3'b000, 2'b10},  // R1 minimal non-zero word
    {32'hFC000000, 4'b0000, 3'b000, 2'b00}   // R5 unknown opcode 3F
  };

  function automatic logic [40:0] vecAt(int idx);
    if (idx < 0 || idx >= NV) return '0;
    return VEC[idx];
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exOut();
    return {exRegDst, exAluOp, exAluSrc};
  endfunction
  function automatic logic [3:0] memOut();
    return {1'b0, memBranch, memRead, memWrite};
  endfunction
  function automatic logic [3:0] wbOut();
    return {2'b00, wbRegWrite, wbMemToReg};
  endfunction

  task automatic stepEdge(logic [31:0] w, logic bub, logic fl);
    @(negedge clk);
    instrWord = w;
    bubbleReq = bub;
    flushReq  = fl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R9 reset ex", exOut(), 4'b0000);
    chk("R9 reset mem", memOut(), 4'b0000);
    chk("R9 reset wb", wbOut(), 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;

    // R1-R6: vector walk, three stages checked in flight
    for (int i = 0; i < NV + 2; i++) begin
      logic [40:0] v0, v1, v2;
      v0 = vecAt(i);
      v1 = vecAt(i - 1);
      v2 = vecAt(i - 2);
      stepEdge((i < NV) ? VEC[i][40:9] : 32'h0, 1'b0, 1'b0);
      chk($sformatf("R6 ex stage vec%0d (R1-R5)", i), exOut(), v0[8:5]);
      chk($sformatf("R6 mem stage vec%0d", i - 1), memOut(), {1'b0, v1[4:2]});
      chk($sformatf("R6 wb stage vec%0d", i - 2), wbOut(), {2'b00, v2[1:0]});
    end

    // R7: bubble over a load following a register-format instruction
    stepEdge(32'h00622020, 1'b0, 1'b0);
    chk("R7 older ex", exOut(), 4'b1100);
    stepEdge(32'h8C220014, 1'b1, 1'b0);
    chk("R7 bubble ex", exOut(), 4'b0000);
    chk("R7 older mem", memOut(), 4'b0000);
    stepEdge(32'h0, 1'b0, 1'b0);
    chk("R7 bubble mem", memOut(), 4'b0000);
    chk("R7 older wb", wbOut(), 4'b0010);
    stepEdge(32'h0, 1'b0, 1'b0);
    chk("R7 bubble wb", wbOut(), 4'b0000);

    // R8: flush kills decode and execute, keeps the older one
    stepEdge(32'h00622020, 1'b0, 1'b0);
    stepEdge(32'h8C220014, 1'b0, 1'b0);
    chk("R8 load in ex", exOut(), 4'b0001);
    stepEdge(32'hAC220014, 1'b0, 1'b1);
    chk("R8 flushed ex", exOut(), 4'b0000);
    chk("R8 flushed mem", memOut(), 4'b0000);
    chk("R8 older wb kept", wbOut(), 4'b0010);
    stepEdge(32'h0, 1'b0, 1'b0);
    chk("R8 killed load wb", wbOut(), 4'b0000);
    chk("R8 killed store mem", memOut(), 4'b0000);

    // R9: asynchronous reset mid-flight
    stepEdge(32'h8C220014, 1'b0, 1'b0);
    stepEdge(32'h8C220014, 1'b0, 1'b0);
    stepEdge(32'h8C220014, 1'b0, 1'b0);
    chk("R9 pre-reset wb", wbOut(), 4'b0011);
    rst_n = 1'b0;
    #1;
    chk("R9 async ex", exOut(), 4'b0000);
    chk("R9 async mem", memOut(), 4'b0000);
    chk("R9 async wb", wbOut(), 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule